// File: doc/BRIEF.md
# Shared Message Memory Arbiter

This block sits in front of a single-port message memory that is shared by one host processor and a number of protocol controllers (two by default). Each cycle it chooses at most one requester, puts that requester's address and command on the memory port, and one cycle later completes the access. For a write it drives the write data on the memory port. For a read it returns the memory's data together with a valid strobe aimed at the requester that won the previous cycle.

Bandwidth is shared dynamically. When the processor and at least one controller are competing, slots alternate between the processor and the controller group, so the processor gets half of the slots. The controllers rotate round-robin through the other half. A party that is idle gives its slots to whoever is asking: a lone controller takes the whole controller half, a silent processor leaves every slot to the controllers, and a silent controller group leaves every slot to the processor. A controller request must have been present for at least one earlier cycle before it can win. Because an access's data phase overlaps the next access's address phase, back-to-back grants sustain one access per cycle.

A requester samples its grant in the cycle it requests. If it is granted, its address is taken in that same cycle. It keeps its request high while it wants further accesses.

Top module: `msgmem_arb`

## Requirements
- R1: At most one of cpu_gnt and ctl_gnt is high in any cycle, and only for a requester whose request is high. In that cycle mem_cmd_vld is high and mem_addr/mem_we carry the winner's address and write flag. mem_cmd_vld is low in every cycle with no grant.
- R2: When no controller is eligible (see R4), a requesting processor is granted in the same cycle, every cycle it requests.
- R3: When the processor and an eligible controller both request, the grant goes to the processor unless the processor took the most recent granted slot. A requesting processor therefore waits at most one cycle. With all parties requesting continuously, the processor receives exactly half of the slots.
- R4: A controller whose request was low in the previous cycle is not eligible and is not granted in the current cycle. A controller whose request was also high in the previous cycle is eligible.
- R5: With the processor idle, eligible controllers receive a grant in every cycle, one access per cycle.
- R6: Among eligible controllers, priority rotates round-robin, starting at controller 0 after reset. After a controller wins, the search starts at the next index. A single eligible controller receives every controller slot.
- R7: One cycle after a write grant, mem_wr_dv is high and mem_wdata equals the write data the winner presented in its grant cycle. mem_wr_dv is low one cycle after a read grant or a cycle with no grant.
- R8: One cycle after a read grant, the rvalid bit of that requester is high and rd_data carries mem_rdata. Controller i uses ctl_rvalid bit i. No rvalid bit is high after a write grant or a cycle with no grant.
- R9: While rst_n is low with all requests low, no grant, mem_cmd_vld, mem_wr_dv or rvalid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor granted this cycle |
| cpu_rvalid | output | 1 | Read data for processor on rd_data |
| ctl_req | input | NCTL | Controller requests, bit i = controller i |
| ctl_we | input | NCTL | Controller write flags |
| ctl_addr | input | NCTL*AW | Controller addresses, controller i at [i*AW +: AW] |
| ctl_wdata | input | NCTL*DW | Controller write data, controller i at [i*DW +: DW] |
| ctl_gnt | output | NCTL | Controller grants |
| ctl_rvalid | output | NCTL | Read data for controller i on rd_data |
| rd_data | output | DW | Read data returned to requesters |
| mem_cmd_vld | output | 1 | Address phase valid |
| mem_we | output | 1 | Address phase is a write |
| mem_addr | output | AW | Address phase address |
| mem_wdata | output | DW | Data phase write data |
| mem_wr_dv | output | 1 | Data phase write strobe |
| mem_rdata | input | DW | Data phase read data from memory |

## Verification
Grants and the address phase respond to requests without a register, so the bench checks them 1 ns after it changes the inputs at the falling edge, within the same cycle. Write data, the write strobe, the read valids and the read data belong to the data phase one rising edge later. The bench records what it expects for them at grant time and compares at the following falling edge, before it drives new inputs. A bench memory that latches the address phase at the rising edge serves the reads, so the returned data is checked against a shadow copy that the bench updates in grant order.

// File: rtl/msgarb_pkg.sv
`timescale 1ns/1ps
package msgarb_pkg;

   // width of an index selecting one of n items (at least 1 bit)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // owner of the most recent granted slot
   typedef enum logic {
      OWN_CTL = 1'b0,
      OWN_CPU = 1'b1
   } slot_own_e;

endpackage

// File: rtl/msgarb_rr.sv
`timescale 1ns/1ps
module msgarb_rr #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] elig,
   input  logic         take,
   output logic [N-1:0] pick
);
   import msgarb_pkg::*;
   localparam int IW = idx_w(N);

   generate
      if (N == 1) begin : g_single
         assign pick = elig;
      end else begin : g_rotate
         logic [IW-1:0] ptr;
         logic [IW-1:0] pick_idx;
         logic          found;

         always_comb begin
            pick     = '0;
            pick_idx = '0;
            found    = 1'b0;
            for (int k = 0; k < N; k++) begin
               int j;
               j = (int'(ptr) + k) % N;
               if (!found && elig[j]) begin
                  found    = 1'b1;
                  pick[j]  = 1'b1;
                  pick_idx = IW'(j);
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr <= '0;
            end else if (take && found) begin
               if (pick_idx == IW'(N - 1)) ptr <= '0;
               else                        ptr <= pick_idx + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/msgarb_slot.sv
`timescale 1ns/1ps
module msgarb_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic ctl_any,
   output logic cpu_win,
   output logic ctl_win
);
   import msgarb_pkg::*;

   slot_own_e last_own;

   always_comb begin
      cpu_win = cpu_req && (!ctl_any || (last_own == OWN_CTL));
      ctl_win = ctl_any && !cpu_win;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_own <= OWN_CTL;
      else if (cpu_win) last_own <= OWN_CPU;
      else if (ctl_win) last_own <= OWN_CTL;
   end
endmodule

// File: rtl/msgarb_dp.sv
`timescale 1ns/1ps
module msgarb_dp #(
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int NREQ = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NREQ-1:0]    gnt,
   input  logic [NREQ-1:0]    we_all,
   input  logic [NREQ*AW-1:0] addr_all,
   input  logic [NREQ*DW-1:0] wdata_all,
   output logic               mem_cmd_vld,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [DW-1:0]      mem_wdata,
   output logic               mem_wr_dv,
   output logic [NREQ-1:0]    rvalid
);
   import msgarb_pkg::*;
   localparam int OW = idx_w(NREQ);

   logic [OW-1:0] a_own;
   logic [DW-1:0] a_wd;

   // address phase: select the single granted requester
   always_comb begin
      mem_cmd_vld = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = '0;
      a_wd        = '0;
      a_own       = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (gnt[i]) begin
            mem_cmd_vld = 1'b1;
            mem_we      = we_all[i];
            mem_addr    = addr_all[i*AW +: AW];
            a_wd        = wdata_all[i*DW +: DW];
            a_own       = OW'(i);
         end
      end
   end

   // data phase registers, overlapping the next address phase
   logic          d_vld;
   logic          d_we;
   logic [OW-1:0] d_own;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_vld <= 1'b0;
         d_we  <= 1'b0;
         d_own <= '0;
      end else begin
         d_vld <= mem_cmd_vld;
         d_we  <= mem_we;
         d_own <= a_own;
      end
   end

   always_ff @(posedge clk) begin
      if (mem_cmd_vld && mem_we) mem_wdata <= a_wd;
   end

   assign mem_wr_dv = d_vld && d_we;

   generate
      for (genvar g = 0; g < NREQ; g++) begin : g_rv
         assign rvalid[g] = d_vld && !d_we && (d_own == OW'(g));
      end
   endgenerate
endmodule

// File: rtl/msgmem_arb.sv
`timescale 1ns/1ps
module msgmem_arb #(
   parameter int AW   = 8,
   parameter int DW   = 32,
   parameter int NCTL = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [AW-1:0]       cpu_addr,
   input  logic [DW-1:0]       cpu_wdata,
   output logic                cpu_gnt,
   output logic                cpu_rvalid,
   input  logic [NCTL-1:0]     ctl_req,
   input  logic [NCTL-1:0]     ctl_we,
   input  logic [NCTL*AW-1:0]  ctl_addr,
   input  logic [NCTL*DW-1:0]  ctl_wdata,
   output logic [NCTL-1:0]     ctl_gnt,
   output logic [NCTL-1:0]     ctl_rvalid,
   output logic [DW-1:0]       rd_data,
   output logic                mem_cmd_vld,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   output logic                mem_wr_dv,
   input  logic [DW-1:0]       mem_rdata
);
   localparam int NREQ = NCTL + 1;

   generate
      if (NCTL < 1) begin : g_bad_nctl
         $error("msgmem_arb: NCTL must be at least 1");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("msgmem_arb: AW and DW must be positive");
      end
   endgenerate

   // a controller request becomes eligible once it has been held a cycle
   logic [NCTL-1:0] ctl_seen;
   logic [NCTL-1:0] ctl_elig;
   logic [NCTL-1:0] ctl_pick;
   logic            cpu_win;
   logic            ctl_win;

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_seen <= '0;
      else        ctl_seen <= ctl_req;
   end

   assign ctl_elig = ctl_req & ctl_seen;

   msgarb_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_req (cpu_req),
      .ctl_any (|ctl_elig),
      .cpu_win (cpu_win),
      .ctl_win (ctl_win)
   );

   msgarb_rr #(.N(NCTL)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (ctl_elig),
      .take  (ctl_win),
      .pick  (ctl_pick)
   );

   assign cpu_gnt = cpu_win;
   assign ctl_gnt = ctl_win ? ctl_pick : '0;

   logic [NREQ-1:0] rv;

   msgarb_dp #(.AW(AW), .DW(DW), .NREQ(NREQ)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .gnt         ({ctl_gnt, cpu_gnt}),
      .we_all      ({ctl_we, cpu_we}),
      .addr_all    ({ctl_addr, cpu_addr}),
      .wdata_all   ({ctl_wdata, cpu_wdata}),
      .mem_cmd_vld (mem_cmd_vld),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_wr_dv   (mem_wr_dv),
      .rvalid      (rv)
   );

   assign cpu_rvalid = rv[0];
   assign ctl_rvalid = rv[NREQ-1:1];
   assign rd_data    = mem_rdata;
endmodule

// File: rtl/msgmem_arb_chk.sv
`timescale 1ns/1ps
module msgmem_arb_chk #(
   parameter int DW   = 32,
   parameter int NCTL = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cpu_req,
   input logic            cpu_we,
   input logic [DW-1:0]   cpu_wdata,
   input logic            cpu_gnt,
   input logic            cpu_rvalid,
   input logic [NCTL-1:0] ctl_req,
   input logic [NCTL-1:0] ctl_we,
   input logic [NCTL-1:0] ctl_gnt,
   input logic [NCTL-1:0] ctl_rvalid,
   input logic            mem_cmd_vld,
   input logic [DW-1:0]   mem_wdata,
   input logic            mem_wr_dv
);
   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_gnt, cpu_gnt}));
   // R1
   cmd_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_vld == (cpu_gnt || (|ctl_gnt)));
   // R1
   cpu_gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |-> cpu_req);
   // R2
   cpu_always_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req |-> (cpu_gnt || (|ctl_gnt)));
   // R3
   cpu_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_gnt) |=> (!cpu_req || cpu_gnt));
   // R7
   wdata_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt && cpu_we) |=> (mem_wr_dv && mem_wdata == $past(cpu_wdata)));
   // R8
   cpu_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_gnt |=> (cpu_rvalid == !$past(cpu_we)));
   // R8
   cpu_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_gnt |=> !cpu_rvalid);

   generate
      for (genvar i = 0; i < NCTL; i++) begin : g_ctl
         // R1
         ctl_gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_gnt[i] |-> ctl_req[i]);
         // R4
         ctl_fresh_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctl_req[i]) |-> !ctl_gnt[i]);
         // R8
         ctl_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_gnt[i] |=> (ctl_rvalid[i] == !$past(ctl_we[i])));
         // R8
         ctl_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_gnt[i] |=> !ctl_rvalid[i]);
      end
   endgenerate
endmodule

bind msgmem_arb msgmem_arb_chk #(.DW(DW), .NCTL(NCTL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_req     (cpu_req),
   .cpu_we      (cpu_we),
   .cpu_wdata   (cpu_wdata),
   .cpu_gnt     (cpu_gnt),
   .cpu_rvalid  (cpu_rvalid),
   .ctl_req     (ctl_req),
   .ctl_we      (ctl_we),
   .ctl_gnt     (ctl_gnt),
   .ctl_rvalid  (ctl_rvalid),
   .mem_cmd_vld (mem_cmd_vld),
   .mem_wdata   (mem_wdata),
   .mem_wr_dv   (mem_wr_dv)
);

// File: tb/tb_msgmem_arb.sv
`timescale 1ns/1ps
module tb_msgmem_arb;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NC = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0]   cpu_addr = '0;
   logic [DW-1:0]   cpu_wdata = '0;
   logic            cpu_gnt, cpu_rvalid;
   logic [NC-1:0]   ctl_req = '0, ctl_we = '0;
   logic [NC*AW-1:0] ctl_addr = '0;
   logic [NC*DW-1:0] ctl_wdata = '0;
   logic [NC-1:0]   ctl_gnt, ctl_rvalid;
   logic [DW-1:0]   rd_data, mem_wdata, mem_rdata;
   logic            mem_cmd_vld, mem_we, mem_wr_dv;
   logic [AW-1:0]   mem_addr;

   always #5 clk = ~clk;

   msgmem_arb #(.AW(AW), .DW(DW), .NCTL(NC)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_gnt(cpu_gnt), .cpu_rvalid(cpu_rvalid),
      .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
      .ctl_gnt(ctl_gnt), .ctl_rvalid(ctl_rvalid), .rd_data(rd_data),
      .mem_cmd_vld(mem_cmd_vld), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_wr_dv(mem_wr_dv), .mem_rdata(mem_rdata)
   );

   // environment memory: address phase latched at the rising edge
   logic [DW-1:0] ram [256];
   logic [DW-1:0] shadow [256];
   logic          cmd_q = 1'b0, we_q = 1'b0;
   logic [AW-1:0] addr_q = '0;

   assign mem_rdata = (cmd_q && !we_q) ? ram[addr_q] : '0;

   always @(posedge clk) begin
      if (mem_wr_dv) ram[addr_q] <= mem_wdata;
      cmd_q  <= mem_cmd_vld;
      we_q   <= mem_we;
      addr_q <= mem_addr;
   end

   int n_chk = 0, n_bad = 0, cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // spec model state
   bit       m_last_cpu = 1'b0;
   int       m_ptr = 0;
   bit [1:0] m_seen = '0;
   // pending data phase expectations
   bit            p_vld = 0, p_we = 0;
   int            p_own = 0;
   logic [DW-1:0] p_wd = '0, p_rd = '0;
   // grant tallies
   int c_cpu = 0, c_k0 = 0, c_k1 = 0, first_k = -1;

   task automatic check_phase();
      chk(mem_wr_dv == (p_vld && p_we), "R7 wr_dv", 64'(mem_wr_dv), 64'(p_vld && p_we));
      if (p_vld && p_we) chk(mem_wdata == p_wd, "R7 wdata", 64'(mem_wdata), 64'(p_wd));
      chk(cpu_rvalid == (p_vld && !p_we && p_own == 0), "R8 cpu_rvalid",
          64'(cpu_rvalid), 64'(p_vld && !p_we && p_own == 0));
      for (int i = 0; i < NC; i++)
         chk(ctl_rvalid[i] == (p_vld && !p_we && p_own == i + 1), "R8 ctl_rvalid",
             64'(ctl_rvalid), 64'(i));
      if (p_vld && !p_we) chk(rd_data == p_rd, "R8 rd_data", 64'(rd_data), 64'(p_rd));
   endtask

   task automatic step(input bit cr, input bit [1:0] kr, input bit cw, input bit [1:0] kw);
      bit [1:0] el;
      bit       e_cpu;
      bit [1:0] e_k;
      int       w;
      string    tag;
      logic [AW-1:0] a [3];
      logic [DW-1:0] d [3];
      @(negedge clk);
      check_phase();
      cyc++;
      for (int r = 0; r < 3; r++) begin
         a[r] = AW'((cyc * (r + 3) + r) % 16);
         d[r] = {16'(cyc), 8'(r), 8'hA5};
      end
      cpu_req = cr; cpu_we = cw; cpu_addr = a[0]; cpu_wdata = d[0];
      ctl_req = kr; ctl_we = kw;
      ctl_addr = {a[2], a[1]}; ctl_wdata = {d[2], d[1]};
      #1;
      el = kr & m_seen;
      e_cpu = cr && (el == 2'b00 || !m_last_cpu);
      e_k = 2'b00;
      if (!e_cpu && el != 2'b00) begin
         if (el[m_ptr]) e_k[m_ptr] = 1'b1;
         else           e_k[1 - m_ptr] = 1'b1;
      end
      if ((kr & ~m_seen) != 2'b00)  tag = "R4 grant";
      else if (cr && el != 2'b00)   tag = "R3 grant";
      else if (cr)                  tag = "R2 grant";
      else if (el == 2'b11)         tag = "R6 grant";
      else                          tag = "R5 grant";
      chk({ctl_gnt, cpu_gnt} == {e_k, e_cpu}, tag, 64'({ctl_gnt, cpu_gnt}), 64'({e_k, e_cpu}));
      w = e_cpu ? 0 : (e_k[0] ? 1 : (e_k[1] ? 2 : -1));
      chk(mem_cmd_vld == (w >= 0), "R1 cmd_vld", 64'(mem_cmd_vld), 64'(w >= 0));
      p_vld = (w >= 0);
      if (w >= 0) begin
         p_we = (w == 0) ? cw : kw[w - 1];
         chk(mem_addr == a[w] && mem_we == p_we, "R1 addr/we",
             64'({mem_we, mem_addr}), 64'({p_we, a[w]}));
         p_own = w; p_wd = d[w]; p_rd = shadow[a[w]];
         if (p_we) shadow[a[w]] = d[w];
         m_last_cpu = (w == 0);
         if (w > 0) m_ptr = (w == 1) ? 1 : 0;
      end
      m_seen = kr;
      if (cpu_gnt) c_cpu++;
      if (ctl_gnt[0]) c_k0++;
      if (ctl_gnt[1]) c_k1++;
      if (first_k < 0 && ctl_gnt != 0) first_k = ctl_gnt[1] ? 1 : 0;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit [15:0] lf;
      for (int i = 0; i < 256; i++) begin
         ram[i] = 32'(i) * 32'h0101_0101;
         shadow[i] = 32'(i) * 32'h0101_0101;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk({cpu_gnt, ctl_gnt, mem_cmd_vld, mem_wr_dv, cpu_rvalid, ctl_rvalid} == '0,
          "R9 reset", 64'({cpu_gnt, ctl_gnt, mem_cmd_vld, mem_wr_dv, cpu_rvalid, ctl_rvalid}), 0);
      rst_n = 1'b1;

      // controllers only, processor idle: R5 and R6
      c_cpu = 0; c_k0 = 0; c_k1 = 0;
      for (int n = 0; n < 20; n++) step(1'b0, 2'b11, 1'b0, 2'b00);
      chk(c_k0 + c_k1 == 19, "R5 ctl slot total", 64'(c_k0 + c_k1), 19);
      chk(first_k == 0, "R6 first winner", 64'(first_k), 0);
      chk(c_k0 == 10 && c_k1 == 9, "R6 rotation split", 64'({c_k0, c_k1}), 64'({32'd10, 32'd9}));
      for (int n = 0; n < 2; n++) step(1'b0, 2'b00, 1'b0, 2'b00);

      // all requesting: R3 half for processor, R6 even split
      c_cpu = 0; c_k0 = 0; c_k1 = 0;
      for (int n = 0; n < 40; n++) step(1'b1, 2'b11, n[0], {n[1], n[2]});
      chk(c_cpu == 20, "R3 cpu half", 64'(c_cpu), 20);
      chk(c_k0 == 10 && c_k1 == 10, "R6 ctl share", 64'({c_k0, c_k1}), 64'({32'd10, 32'd10}));
      for (int n = 0; n < 2; n++) step(1'b0, 2'b00, 1'b0, 2'b00);

      // processor alone: R2 every cycle
      c_cpu = 0;
      for (int n = 0; n < 10; n++) step(1'b1, 2'b00, n[0], 2'b00);
      chk(c_cpu == 10, "R2 cpu alone", 64'(c_cpu), 10);

      // single controller with processor: R6 sole controller takes controller half
      c_cpu = 0; c_k1 = 0;
      for (int n = 0; n < 21; n++) step(1'b1, 2'b10, 1'b0, {n[0], 1'b0});
      chk(c_k1 == 10 && c_cpu == 11, "R6 sole controller", 64'({c_cpu, c_k1}), 64'({32'd11, 32'd10}));

      // sweep of every request pattern and write mix
      for (int p = 0; p < 8; p++)
         for (int wv = 0; wv < 4; wv++)
            for (int r = 0; r < 2; r++)
               step(p[2], p[1:0], wv[0], wv[1:0]);

      // pseudo-random pattern run
      lf = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] | lf[7], lf[3:2], lf[4], lf[6:5]);
      end
      step(1'b0, 2'b00, 1'b0, 2'b00);
      step(1'b0, 2'b00, 1'b0, 2'b00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule